// File: doc/BRIEF.md
# Unrolled Linear Recurrent Cell Array

This block computes the hidden vector of a recurrent layer without running the recurrence step by step. The nonlinearity is dropped and the recurrence is unrolled over a fixed window of five embedded instruction vectors. The block can therefore treat each window position as an independent feedforward term. Position k (k = 0 for the current instruction, k = 4 for the oldest) owns a precomputed 8x8 matrix, equal to the feedback matrix raised to the power k times the input matrix. The block multiplies that matrix against the embedded vector of position k and adds one combined bias vector to the sum of the five products.

Every lane holds five multiply-accumulate arrays, one per window position, and all five work in parallel. Each array has eight MAC elements, one per hidden element. In each of eight steps the array consumes one input element and one matrix row, so the 8-element product is complete after eight steps. Seven lanes take whole windows in strict round-robin order over a valid/ready input. The lanes retire through a single registered output stage in the same order the windows were accepted. All operands are signed Q16.16. Sums are kept at full precision and reduced to 32 bits once, with saturation. Matrices and bias are loaded beforehand through a simple write port.

Top module: `unrolled_cell_array`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and all weights and bias read as zero.
- R2: Each output element j equals floor((sum over k,i of x_k[i]·M_k[i][j] + B[j]·2^16) / 2^16). x, M and B are signed Q16.16 and the whole sum is kept exact before this single rounding. No activation is applied, so negative results pass through unchanged.
- R3: A result above 0x7FFFFFFF is output as 0x7FFFFFFF, and a result below 0x80000000 is output as 0x80000000.
- R4: Element i of window position k sits at `in_win[(k*8+i)*32 +: 32]`, and hidden element j at `out_hid[j*32 +: 32]`. A write with `wgt_sel` = k (0..4) stores `wgt_data` as M_k[`wgt_row`][`wgt_col`], where the row selects the input element and the column the hidden element. `wgt_sel` = 5 stores bias element `wgt_col`.
- R5: A window accepted at rising edge n makes `out_valid` rise just after edge n+8, provided the output stage is free. These are eight MAC steps followed by the output register.
- R6: While `out_ready` is held low, exactly eight windows (lanes plus output stage) are accepted, after which `in_ready` stays low.
- R7: Results leave in exactly the order their windows were accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_hid` hold their values.
- R9: With `in_valid` and `out_ready` held high, fourteen windows are accepted within fifteen consecutive cycles: seven back to back, one bubble, then seven more.
- R10: A weight write with `wgt_sel` of 6 or 7 changes no matrix entry and no bias element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wgt_we | input | 1 | Weight write strobe |
| wgt_sel | input | 3 | 0..4 matrix of that window position, 5 bias, 6..7 ignored |
| wgt_row | input | 3 | Input element index of the matrix entry |
| wgt_col | input | 3 | Hidden element index (matrix column or bias element) |
| wgt_data | input | 32 | Q16.16 value to store |
| in_valid | input | 1 | Window on `in_win` is valid |
| in_ready | output | 1 | A lane can take the window this cycle |
| in_win | input | 1280 | Five embedded vectors of eight Q16.16 elements |
| out_valid | output | 1 | `out_hid` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hid | output | 256 | Eight saturated Q16.16 hidden elements |

## Verification
A window handed over at one rising edge is due on the output just after the eighth edge that follows. The bench drives and samples one nanosecond before each rising edge. It therefore sees `out_valid` nine samples after the sample in which it saw the handshake, and it checks that distance exactly. The bench records acceptance and retirement sample indices, so capacity under stall is judged at the sample where `out_ready` first rises and throughput by the span between first and last acceptance. Every popped result is compared against a reference model computed from the bench's own copy of the loaded weights, in acceptance order.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
  localparam int DW    = 32;
  localparam int FRAC  = 16;
  localparam int VEC   = 8;
  localparam int WIN   = 5;
  localparam int IDX_W = $clog2(VEC);
  localparam int SEL_W = $clog2(WIN + 1);
  localparam int ACC_W = 2 * DW + IDX_W + 1;
  localparam int SUM_W = ACC_W + $clog2(WIN + 1) + 1;
  localparam int WINB  = WIN * VEC * DW;
  localparam int HIDB  = VEC * DW;
  localparam int ACCB  = WIN * VEC * ACC_W;
  localparam int MATB  = WIN * VEC * VEC * DW;

  typedef logic signed [DW-1:0]    word_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [SUM_W-1:0] sum_t;
  typedef enum logic [1:0] {LN_FREE, LN_RUN, LN_DONE} lane_st_t;

  localparam sum_t SUM_MAX = (sum_t'(1) <<< (DW - 1)) - sum_t'(1);
  localparam sum_t SUM_MIN = -(sum_t'(1) <<< (DW - 1));

  // one exact Q32.32 product, widened for accumulation
  function automatic acc_t mac_term(input word_t x, input word_t w);
    logic signed [2*DW-1:0] p;
    p = x * w;
    return acc_t'(p);
  endfunction

  // drop the fraction bits once, then clamp to a 32-bit word
  function automatic word_t sat_word(input sum_t v);
    sum_t s;
    s = v >>> FRAC;
    if (s > SUM_MAX)      return {1'b0, {(DW-1){1'b1}}};
    else if (s < SUM_MIN) return {1'b1, {(DW-1){1'b0}}};
    else                  return word_t'(s[DW-1:0]);
  endfunction

  // hidden element j: five array partial sums plus the bias
  function automatic word_t fold_elem(input logic [ACCB-1:0] accs, input word_t b,
                                      input int j);
    sum_t s;
    s = sum_t'(b) <<< FRAC;
    for (int k = 0; k < WIN; k++)
      s = s + sum_t'(acc_t'(accs[(k*VEC + j)*ACC_W +: ACC_W]));
    return sat_word(s);
  endfunction
endpackage

// File: rtl/ulc_weight_store.sv
module ulc_weight_store
  import ulc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] row,
  input  logic [IDX_W-1:0] col,
  input  logic [DW-1:0]    data,
  output logic [MATB-1:0]  mat_flat,
  output logic [HIDB-1:0]  bias_flat
);
  localparam int NW = WIN * VEC * VEC;

  logic [DW-1:0] mat_q  [NW];
  logic [DW-1:0] bias_q [VEC];

  logic hit_mat, hit_bias;
  assign hit_mat  = we && (sel < SEL_W'(WIN));
  assign hit_bias = we && (sel == SEL_W'(WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NW; n++) mat_q[n] <= '0;
      for (int n = 0; n < VEC; n++) bias_q[n] <= '0;
    end else if (hit_mat) begin
      mat_q[(int'(sel)*VEC + int'(row))*VEC + int'(col)] <= data;
    end else if (hit_bias) begin
      bias_q[int'(col)] <= data;
    end
  end

  for (genvar n = 0; n < NW; n++) begin : g_mat
    assign mat_flat[n*DW +: DW] = mat_q[n];
  end
  for (genvar n = 0; n < VEC; n++) begin : g_bias
    assign bias_flat[n*DW +: DW] = bias_q[n];
  end
endmodule

// File: rtl/ulc_mac_array.sv
module ulc_mac_array
  import ulc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step,
  input  word_t                x_elem,
  input  logic [VEC*DW-1:0]    w_row,
  output logic [VEC*ACC_W-1:0] acc_flat
);
  for (genvar j = 0; j < VEC; j++) begin : g_mac
    word_t w_j;
    acc_t  acc_q;
    assign w_j = word_t'(w_row[j*DW +: DW]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (start) acc_q <= mac_term(x_elem, w_j);
      else if (step)  acc_q <= acc_q + mac_term(x_elem, w_j);
    end

    assign acc_flat[j*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/ulc_lane.sv
module ulc_lane
  import ulc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            retire,
  input  logic [WINB-1:0] win_in,
  input  logic [MATB-1:0] mat_flat,
  output logic            is_free,
  output logic            is_done,
  output logic [ACCB-1:0] acc_all
);
  lane_st_t         st_q;
  logic [IDX_W-1:0] cnt_q;
  logic [WINB-1:0]  x_q;
  logic [IDX_W-1:0] row_sel;
  logic             step_en;

  assign row_sel = start ? '0 : cnt_q;
  assign step_en = (st_q == LN_RUN);
  assign is_free = (st_q == LN_FREE);
  assign is_done = (st_q == LN_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_FREE;
      cnt_q <= '0;
      x_q   <= '0;
    end else if (start) begin
      st_q  <= LN_RUN;
      cnt_q <= IDX_W'(1);
      x_q   <= win_in;
    end else begin
      case (st_q)
        LN_RUN: begin
          cnt_q <= cnt_q + IDX_W'(1);
          if (cnt_q == IDX_W'(VEC - 1)) st_q <= LN_DONE;
        end
        LN_DONE: if (retire) st_q <= LN_FREE;
        default: st_q <= LN_FREE;
      endcase
    end
  end

  for (genvar k = 0; k < WIN; k++) begin : g_pos
    word_t             x_sel;
    logic [VEC*DW-1:0] row_w;
    assign x_sel = start ? word_t'(win_in[(k*VEC)*DW +: DW])
                         : word_t'(x_q[(k*VEC + int'(cnt_q))*DW +: DW]);
    assign row_w = mat_flat[(k*VEC + int'(row_sel))*VEC*DW +: VEC*DW];

    ulc_mac_array u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .step     (step_en),
      .x_elem   (x_sel),
      .w_row    (row_w),
      .acc_flat (acc_all[k*VEC*ACC_W +: VEC*ACC_W])
    );
  end
endmodule

// File: rtl/unrolled_cell_array.sv
module unrolled_cell_array
  import ulc_pkg::*;
#(
  parameter int LANES = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wgt_we,
  input  logic [SEL_W-1:0]       wgt_sel,
  input  logic [IDX_W-1:0]       wgt_row,
  input  logic [IDX_W-1:0]       wgt_col,
  input  logic [DW-1:0]          wgt_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WINB-1:0]        in_win,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [HIDB-1:0]        out_hid
);
  localparam int PTR_W = $clog2(LANES);

  logic [MATB-1:0]  mat_flat;
  logic [HIDB-1:0]  bias_flat;
  logic [LANES-1:0] lane_free, lane_done, lane_start, lane_retire;
  logic [ACCB-1:0]  lane_acc [LANES];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [HIDB-1:0]  hid_next;

  // named events for the checker
  logic accept_evt, retire_evt;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(LANES - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  ulc_weight_store u_wst (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wgt_we),
    .sel       (wgt_sel),
    .row       (wgt_row),
    .col       (wgt_col),
    .data      (wgt_data),
    .mat_flat  (mat_flat),
    .bias_flat (bias_flat)
  );

  assign retire_evt = lane_done[rd_ptr] && (!out_valid || out_ready);
  assign in_ready   = lane_free[wr_ptr] || (retire_evt && (rd_ptr == wr_ptr));
  assign accept_evt = in_valid && in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_start[l]  = accept_evt && (wr_ptr == PTR_W'(l));
    assign lane_retire[l] = retire_evt && (rd_ptr == PTR_W'(l));

    ulc_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (lane_start[l]),
      .retire   (lane_retire[l]),
      .win_in   (in_win),
      .mat_flat (mat_flat),
      .is_free  (lane_free[l]),
      .is_done  (lane_done[l]),
      .acc_all  (lane_acc[l])
    );
  end

  for (genvar j = 0; j < VEC; j++) begin : g_fold
    assign hid_next[j*DW +: DW] =
      fold_elem(lane_acc[rd_ptr], word_t'(bias_flat[j*DW +: DW]), j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_hid   <= '0;
    end else begin
      if (accept_evt) wr_ptr <= ptr_next(wr_ptr);
      if (retire_evt) begin
        rd_ptr    <= ptr_next(rd_ptr);
        out_valid <= 1'b1;
        out_hid   <= hid_next;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ulc_array_chk.sv
module ulc_array_chk
  import ulc_pkg::*;
#(
  parameter int LANES = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [HIDB-1:0]  out_hid,
  input logic             accept_evt,
  input logic             retire_evt,
  input logic [LANES-1:0] lane_free
);
  int unsigned acc_cnt, pop_cnt, ret_cnt;
  logic [7:0]  age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= 0;
      pop_cnt <= 0;
      ret_cnt <= 0;
      age     <= '0;
    end else begin
      if (in_valid && in_ready)   acc_cnt <= acc_cnt + 1;
      if (out_valid && out_ready) pop_cnt <= pop_cnt + 1;
      if (retire_evt)             ret_cnt <= ret_cnt + 1;
      if (accept_evt)             age <= 8'd1;
      else if (age != 8'hFF)      age <= age + 8'd1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hid)); // R8
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt - pop_cnt) <= LANES + 1); // R6
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pop_cnt < acc_cnt); // R7
  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt && (acc_cnt - ret_cnt == 1) |-> age >= 8'(VEC)); // R5
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_free) |-> in_ready); // R1
endmodule

bind unrolled_cell_array ulc_array_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_hid    (out_hid),
  .accept_evt (accept_evt),
  .retire_evt (retire_evt),
  .lane_free  (lane_free)
);

// File: tb/unrolled_cell_array_tb_top.sv
module unrolled_cell_array_tb_top;
  import ulc_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wgt_we = 1'b0;
  logic [SEL_W-1:0] wgt_sel = '0;
  logic [IDX_W-1:0] wgt_row = '0, wgt_col = '0;
  logic [DW-1:0]    wgt_data = '0;
  logic             in_valid = 1'b0, in_ready;
  logic [WINB-1:0]  in_win = '0;
  logic             out_valid, out_ready = 1'b1;
  logic [HIDB-1:0]  out_hid;

  always #2 clk = ~clk;

  unrolled_cell_array dut_i (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int bw [WIN][VEC][VEC];
  int bb [VEC];
  logic [WINB-1:0] src [16];

  typedef struct packed { int seed; logic [4:0] kmask; } tv_t;
  localparam int TBL_N = 6;
  localparam tv_t TBL [TBL_N] = '{
    '{32'd11, 5'b00001}, '{32'd23, 5'b10000}, '{32'd37, 5'b01000},
    '{32'd41, 5'b11111}, '{32'd53, 5'b10101}, '{32'd67, 5'b00110}};

  task automatic chk(input bit ok, input string req, input logic [HIDB-1:0] act,
                     input logic [HIDB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [HIDB-1:0] model(input logic [WINB-1:0] w);
    logic [HIDB-1:0] r;
    for (int j = 0; j < VEC; j++) begin
      logic signed [95:0] s;
      logic signed [95:0] q;
      s = 96'(bb[j]) * 96'sd65536;
      for (int k = 0; k < WIN; k++)
        for (int i = 0; i < VEC; i++) begin
          longint p;
          p = longint'(int'(w[(k*VEC+i)*DW +: DW])) * longint'(bw[k][i][j]);
          s = s + 96'(p);
        end
      q = s >>> 16;
      if (q > 96'sd2147483647)       r[j*DW +: DW] = 32'h7FFFFFFF;
      else if (q < -96'sd2147483648) r[j*DW +: DW] = 32'h80000000;
      else                           r[j*DW +: DW] = q[31:0];
    end
    return r;
  endfunction

  function automatic logic [WINB-1:0] gen_win(input int seed, input logic [4:0] kmask);
    logic [WINB-1:0] r = '0;
    logic [31:0] st = seed;
    for (int k = 0; k < WIN; k++)
      for (int i = 0; i < VEC; i++) begin
        st = st * 32'd1664525 + 32'd1013904223;
        if (kmask[k]) r[(k*VEC+i)*DW +: DW] = int'({13'b0, st[31:13]}) - 262144;
      end
    return r;
  endfunction

  task automatic write_w(input int sel, input int row, input int col, input int val);
    @(negedge clk);
    wgt_we = 1'b1; wgt_sel = SEL_W'(sel); wgt_row = IDX_W'(row);
    wgt_col = IDX_W'(col); wgt_data = val;
    if (sel < WIN) bw[sel][row][col] = val;
    else if (sel == WIN) bb[col] = val;
    @(negedge clk);
    wgt_we = 1'b0;
  endtask

  task automatic load_rand(input int seed);
    logic [31:0] st = seed;
    for (int k = 0; k < WIN; k++)
      for (int i = 0; i < VEC; i++)
        for (int j = 0; j < VEC; j++) begin
          st = st * 32'd22695477 + 32'd1;
          write_w(k, i, j, int'({14'b0, st[31:14]}) - 131072);
        end
    for (int j = 0; j < VEC; j++) begin
      st = st * 32'd22695477 + 32'd1;
      write_w(WIN, 0, j, int'({11'b0, st[31:11]}) - 1048576);
    end
  endtask

  // drives src[0..n-1]; out_ready low for the first 'stall' samples
  task automatic run_stream(input int n, input int stall, input string req,
                            output int first_acc, output int last_acc,
                            output int first_out, output int acc_at_stall);
    int sent = 0, got = 0, cyc = 0;
    logic [HIDB-1:0] prev_hid = '0;
    bit prev_hold = 0;
    first_acc = -1; last_acc = -1; first_out = -1; acc_at_stall = -1;
    while (got < n && cyc < 500) begin
      @(negedge clk);
      in_valid  = (sent < n);
      in_win    = (sent < n) ? src[sent] : '0;
      out_ready = (cyc >= stall);
      #1;
      if (prev_hold) chk(out_valid && out_hid == prev_hid, "R8", out_hid, prev_hid);
      prev_hold = out_valid && !out_ready;
      prev_hid  = out_hid;
      if (cyc == stall) acc_at_stall = sent;
      if (out_valid && out_ready) begin
        if (first_out < 0) first_out = cyc;
        chk(out_hid == model(src[got]), req, out_hid, model(src[got]));
        got++;
      end
      if (in_valid && in_ready) begin
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    chk(got == n, {req, " count"}, HIDB'(got), HIDB'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int fa, la, fo, as;
    for (int k = 0; k < WIN; k++)
      for (int i = 0; i < VEC; i++)
        for (int j = 0; j < VEC; j++) bw[k][i][j] = 0;
    for (int j = 0; j < VEC; j++) bb[j] = 0;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", HIDB'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
        HIDB'({in_ready, out_valid}), HIDB'(2'b10));
    // zero weights: any window gives zero (R1)
    src[0] = gen_win(5, 5'b11111);
    run_stream(1, 0, "R1 zero weights", fa, la, fo, as);

    load_rand(99);

    // table walk: R2 arithmetic, R4 position addressing
    for (int t = 0; t < TBL_N; t++) begin
      src[0] = gen_win(TBL[t].seed, TBL[t].kmask);
      run_stream(1, 0, "R2 R4 table", fa, la, fo, as);
      if (t == 0) chk(fo - fa == 9, "R5 latency", HIDB'(fo - fa), HIDB'(9));
    end

    // R6 capacity under stall, R7 order, R8 hold
    for (int n = 0; n < 10; n++) src[n] = gen_win(200 + n, 5'b11111);
    run_stream(10, 20, "R7 order", fa, la, fo, as);
    chk(as == 8, "R6 capacity", HIDB'(as), HIDB'(8));

    // R9 throughput
    for (int n = 0; n < 14; n++) src[n] = gen_win(300 + n, 5'b11111);
    run_stream(14, 0, "R9 stream", fa, la, fo, as);
    chk(la - fa == 14, "R9 span", HIDB'(la - fa), HIDB'(14));

    // R10 ignored selectors
    write_w(6, 0, 0, 32'h12345678);
    write_w(7, 1, 1, 32'h7FFFFFFF);
    src[0] = gen_win(77, 5'b11111);
    run_stream(1, 0, "R10 bad selector", fa, la, fo, as);

    // R3 saturation using position 0 only
    for (int i = 0; i < VEC; i++)
      for (int j = 0; j < VEC; j++) write_w(0, i, j, 32'h40000000);
    src[0] = '0; src[1] = '0;
    for (int i = 0; i < VEC; i++) begin
      src[0][i*DW +: DW] = 32'h40000000;
      src[1][i*DW +: DW] = 32'hC0000000;
    end
    run_stream(2, 0, "R3 saturation", fa, la, fo, as);
    chk(model(src[0]) == {VEC{32'h7FFFFFFF}}, "R3 high clamp", model(src[0]),
        {VEC{32'h7FFFFFFF}});
    chk(model(src[1]) == {VEC{32'h80000000}}, "R3 low clamp", model(src[1]),
        {VEC{32'h80000000}});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule